// File: doc/BRIEF.md
# Per-Phase Breaker Failure Sequencer

This block decides, separately for each of three phases, whether a circuit breaker has failed to interrupt fault current after protection has ordered it open. Once a phase has been started, it runs two delayed-pickup stages. The first stage re-issues a trip to the original breaker. The second stage trips the neighbouring breakers if current is still flowing. A back-trip on any phase becomes a three-phase final trip, and that trip also blocks autoreclose.

Time advances on a one-millisecond tick enable (`tick_1ms`), one system clock wide. Both delays are given in milliseconds and are clamped into the permitted range. The design has no data stream, so there is no valid/ready handshake. Every pin is a plain level-sensitive control or status signal, sampled on the rising clock edge. Current measurement and the overcurrent comparator are outside this block, which only receives the resulting per-phase flags.

Top module: `brkfail_seq`

## Requirements
- R1: A phase is started when its internal initiation is high, or when its external initiation is high and `ext_start_en` is 1. While `ext_start_en` is 0, the external initiation inputs have no effect on any output.
- R2: When a phase's start condition goes low, that phase's retrip and back-trip outputs are low after the next clock edge, and both of its delay counts restart from zero.
- R3: A phase's back-trip counts ticks only while its overcurrent flag is high. A tick with the flag low clears the count. Back-trip asserts on the tick that brings the count to the effective back-trip delay.
- R4: Retrip mode code 1 (direct) counts ticks while the phase is started, whatever the overcurrent flag. Retrip asserts on the tick that brings the count to the effective retrip delay.
- R5: Retrip mode code 2 (current-checked) counts ticks only while the overcurrent flag is high. A tick with the flag low clears the count. This means a breaker that clears before both delays expire leaves every output low.
- R6: Retrip mode codes 0 and 3 (off) keep every retrip output low.
- R7: When `backtrip_en` is 0, every back-trip output is low after the next clock edge, and `trip_3ph` stays low.
- R8: Each delay setting is clamped into the range 50 to 500. A setting below 50 acts as 50, and a setting above 500 acts as 500.
- R9: `trip_3ph` and `reclose_block` are high whenever any phase's back-trip output is high.
- R10: While `block_in` is high, all outputs are low after the next clock edge and all counts are held at zero. After release, the delays run again in full.
- R11: Phases time independently. A phase that starts while another is still timing does not shift the other phase's output time.
- R12: Once asserted, a retrip or back-trip output stays high, even if the overcurrent flag drops, until that phase's start condition drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse each millisecond |
| int_init | input | 3 | Internal initiation, one bit per phase |
| ext_init | input | 3 | External initiation, one bit per phase |
| oc_flag | input | 3 | Overcurrent detected, one bit per phase |
| retrip_mode | input | 2 | 0/3 off, 1 direct, 2 current-checked |
| backtrip_en | input | 1 | Enables back-trip outputs |
| ext_start_en | input | 1 | Enables start from external initiation |
| retrip_dly_ms | input | DW | Retrip delay in ms |
| backtrip_dly_ms | input | DW | Back-trip delay in ms |
| block_in | input | 1 | Clears all timing and outputs while high |
| retrip_out | output | 3 | Retrip of the original breaker, per phase |
| backtrip_out | output | 3 | Back-trip of adjacent breakers, per phase |
| trip_3ph | output | 1 | Three-phase final trip |
| reclose_block | output | 1 | Autoreclose blocked |

## Verification
The hardest situation to reach from the ports is an evolving fault. In that case a second phase must start part-way through the first phase's back-trip wait, and both outputs must land on their own exact tick counts. The bench starts phase A, advances a known number of ticks, and then starts phase B. It then samples on the tick just before and just after each phase's expected edge. A one-tick dip of the overcurrent flag, placed mid-wait, shows that the back-trip wait restarts rather than resumes.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    RT_OFF     = 2'd0,
    RT_DIRECT  = 2'd1,
    RT_CURRENT = 2'd2,
    RT_OFF_ALT = 2'd3
  } rt_mode_e;

  localparam int NUM_PHASES = 3;
endpackage

// File: rtl/bfs_delay_timer.sv
module bfs_delay_timer #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [DW-1:0] limit,
  output logic          hit
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] cnt_inc;
  logic          sat;

  assign cnt_inc = cnt + 1'b1;
  assign hit     = run & tick & ~sat & (cnt_inc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sat <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sat <= 1'b0;
    end else if (tick && !sat) begin
      cnt <= cnt_inc;
      sat <= (cnt_inc == limit);
    end
  end
endmodule

// File: rtl/bfs_phase.sv
module bfs_phase
  import bfs_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          oc,
  input  logic          block,
  input  logic          bt_en,
  input  rt_mode_e      mode,
  input  logic [DW-1:0] rt_lim,
  input  logic [DW-1:0] bt_lim,
  output logic          retrip,
  output logic          backtrip
);
  logic rt_active;
  logic rt_run;
  logic bt_run;
  logic rt_hit;
  logic bt_hit;

  assign rt_active = (mode == RT_DIRECT) || (mode == RT_CURRENT);
  assign rt_run    = start & ~block &
                     ((mode == RT_DIRECT) | ((mode == RT_CURRENT) & oc));
  assign bt_run    = start & ~block & oc;

  bfs_delay_timer #(.DW(DW)) u_rt_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(rt_run),
    .limit(rt_lim), .hit(rt_hit)
  );

  bfs_delay_timer #(.DW(DW)) u_bt_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(bt_run),
    .limit(bt_lim), .hit(bt_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retrip <= 1'b0;
    end else if (!start || block || !rt_active) begin
      retrip <= 1'b0;
    end else if (rt_hit) begin
      retrip <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      backtrip <= 1'b0;
    end else if (!start || block || !bt_en) begin
      backtrip <= 1'b0;
    end else if (bt_hit) begin
      backtrip <= 1'b1;
    end
  end
endmodule

// File: rtl/brkfail_seq.sv
module brkfail_seq
  import bfs_pkg::*;
#(
  parameter int DW      = 10,
  parameter int MIN_DLY = 50,
  parameter int MAX_DLY = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1ms,
  input  logic [2:0]    int_init,
  input  logic [2:0]    ext_init,
  input  logic [2:0]    oc_flag,
  input  logic [1:0]    retrip_mode,
  input  logic          backtrip_en,
  input  logic          ext_start_en,
  input  logic [DW-1:0] retrip_dly_ms,
  input  logic [DW-1:0] backtrip_dly_ms,
  input  logic          block_in,
  output logic [2:0]    retrip_out,
  output logic [2:0]    backtrip_out,
  output logic          trip_3ph,
  output logic          reclose_block
);
  localparam logic [DW-1:0] LO_LIM = DW'(MIN_DLY);
  localparam logic [DW-1:0] HI_LIM = DW'(MAX_DLY);

  function automatic logic [DW-1:0] clamp_dly(input logic [DW-1:0] v);
    if (v < LO_LIM)      return LO_LIM;
    else if (v > HI_LIM) return HI_LIM;
    else                 return v;
  endfunction

  rt_mode_e          mode;
  logic [DW-1:0]     rt_lim;
  logic [DW-1:0]     bt_lim;
  logic [NUM_PHASES-1:0] start;

  assign mode   = rt_mode_e'(retrip_mode);
  assign rt_lim = clamp_dly(retrip_dly_ms);
  assign bt_lim = clamp_dly(backtrip_dly_ms);
  assign start  = int_init | (ext_init & {NUM_PHASES{ext_start_en}});

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_ph
    bfs_phase #(.DW(DW)) u_phase (
      .clk(clk), .rst_n(rst_n), .tick(tick_1ms),
      .start(start[p]), .oc(oc_flag[p]), .block(block_in),
      .bt_en(backtrip_en), .mode(mode),
      .rt_lim(rt_lim), .bt_lim(bt_lim),
      .retrip(retrip_out[p]), .backtrip(backtrip_out[p])
    );
  end

  assign trip_3ph      = |backtrip_out;
  assign reclose_block = |backtrip_out;
endmodule

// File: rtl/brkfail_seq_chk.sv
module brkfail_seq_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    int_init,
  input logic [2:0]    oc_flag,
  input logic [1:0]    retrip_mode,
  input logic          backtrip_en,
  input logic          ext_start_en,
  input logic          block_in,
  input logic [2:0]    retrip_out,
  input logic [2:0]    backtrip_out
);
  assert_block_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    block_in |=> (retrip_out == 3'b000) && (backtrip_out == 3'b000));

  assert_retrip_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retrip_mode == 2'd0 || retrip_mode == 2'd3) |=> (retrip_out == 3'b000));

  assert_bt_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !backtrip_en |=> (backtrip_out == 3'b000));

  for (genvar p = 0; p < 3; p++) begin : g_chk
    assert_ext_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_init[p] && !ext_start_en) |=> (!retrip_out[p] && !backtrip_out[p]));

    assert_bt_needs_current_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(backtrip_out[p]) |-> $past(oc_flag[p]));
  end
endmodule

bind brkfail_seq brkfail_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_brkfail_seq.sv
module tb_brkfail_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_1ms = 1'b0;
  logic [2:0]    int_init = '0;
  logic [2:0]    ext_init = '0;
  logic [2:0]    oc_flag = '0;
  logic [1:0]    retrip_mode = 2'd0;
  logic          backtrip_en = 1'b1;
  logic          ext_start_en = 1'b1;
  logic [DW-1:0] retrip_dly_ms = 10'd60;
  logic [DW-1:0] backtrip_dly_ms = 10'd100;
  logic          block_in = 1'b0;
  logic [2:0]    retrip_out;
  logic [2:0]    backtrip_out;
  logic          trip_3ph;
  logic          reclose_block;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brkfail_seq #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
    .int_init(int_init), .ext_init(ext_init), .oc_flag(oc_flag),
    .retrip_mode(retrip_mode), .backtrip_en(backtrip_en),
    .ext_start_en(ext_start_en), .retrip_dly_ms(retrip_dly_ms),
    .backtrip_dly_ms(backtrip_dly_ms), .block_in(block_in),
    .retrip_out(retrip_out), .backtrip_out(backtrip_out),
    .trip_3ph(trip_3ph), .reclose_block(reclose_block)
  );

  // observed vector: [7] trip_3ph, [6] reclose_block, [5:3] backtrip, [2:0] retrip
  function automatic logic [7:0] obs();
    return {trip_3ph, reclose_block, backtrip_out, retrip_out};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = obs();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1'b1;
      @(negedge clk) tick_1ms = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    int_init = '0; ext_init = '0; oc_flag = '0; block_in = 1'b0;
    backtrip_en = 1'b1; ext_start_en = 1'b1;
    retrip_dly_ms = 10'd60; backtrip_dly_ms = 10'd100;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_normal_clear();
    retrip_mode = 2'd2; retrip_dly_ms = 10'd100; backtrip_dly_ms = 10'd150;
    int_init = 3'b001; oc_flag = 3'b001;
    ticks(60);
    check("R5 timing before clearance", 8'h00);
    oc_flag = 3'b000;
    ticks(200);
    check("R5 R3 cleared breaker stays idle", 8'h00);
    settle();
  endtask

  task automatic t_fail_mode(input logic [1:0] m);
    logic [7:0] rt;
    rt = (m == 2'd1 || m == 2'd2) ? 8'h01 : 8'h00;
    retrip_mode = m;
    int_init = 3'b001; oc_flag = 3'b001;
    ticks(59);
    check("R4 R5 retrip not before delay", 8'h00);
    ticks(1);
    check("R4 R5 R6 retrip at delay", rt);
    ticks(39);
    check("R3 backtrip not before delay", rt);
    ticks(1);
    check("R3 R9 backtrip at delay", 8'hC8 | rt);
    if (m == 2'd2) begin
      oc_flag = 3'b000;
      ticks(5);
      check("R12 outputs held after current drops", 8'hC9);
    end
    int_init = 3'b000;
    @(negedge clk);
    check("R2 initiation drop resets phase", 8'h00);
    settle();
  endtask

  task automatic t_direct_no_current();
    retrip_mode = 2'd1;
    int_init = 3'b010;
    ticks(59);
    check("R4 direct retrip not early", 8'h00);
    ticks(1);
    check("R4 direct retrip without current", 8'h02);
    ticks(80);
    check("R3 no backtrip without current", 8'h02);
    settle();
  endtask

  task automatic t_oc_dip();
    retrip_mode = 2'd0; backtrip_dly_ms = 10'd80;
    int_init = 3'b100; oc_flag = 3'b100;
    ticks(50);
    oc_flag = 3'b000;
    ticks(1);
    oc_flag = 3'b100;
    ticks(79);
    check("R3 dip restarts backtrip wait", 8'h00);
    ticks(1);
    check("R3 backtrip after full restarted wait", 8'hE0);
    settle();
  endtask

  task automatic t_evolving();
    retrip_mode = 2'd0;
    int_init = 3'b001; oc_flag = 3'b001;
    ticks(40);
    int_init = 3'b011; oc_flag = 3'b011;
    ticks(59);
    check("R11 phase A not early", 8'h00);
    ticks(1);
    check("R11 phase A on its own time", 8'hC8);
    ticks(39);
    check("R11 phase B not early", 8'hC8);
    ticks(1);
    check("R11 phase B on its own time", 8'hD8);
    settle();
  endtask

  task automatic t_ext_start();
    retrip_mode = 2'd1; ext_start_en = 1'b0;
    ext_init = 3'b001; oc_flag = 3'b001;
    ticks(120);
    check("R1 external start ignored when disabled", 8'h00);
    ext_start_en = 1'b1;
    ticks(60);
    check("R1 external start retrip", 8'h01);
    ticks(40);
    check("R1 external start backtrip", 8'hC9);
    settle();
  endtask

  task automatic t_bt_disabled();
    retrip_mode = 2'd1; backtrip_en = 1'b0;
    int_init = 3'b001; oc_flag = 3'b001;
    ticks(150);
    check("R7 backtrip suppressed", 8'h01);
    settle();
  endtask

  task automatic t_clamp();
    retrip_mode = 2'd1; retrip_dly_ms = 10'd10; backtrip_dly_ms = 10'd900;
    int_init = 3'b001; oc_flag = 3'b001;
    ticks(49);
    check("R8 low setting acts as 50 (before)", 8'h00);
    ticks(1);
    check("R8 low setting acts as 50", 8'h01);
    ticks(449);
    check("R8 high setting acts as 500 (before)", 8'h01);
    ticks(1);
    check("R8 high setting acts as 500", 8'hC9);
    settle();
  endtask

  task automatic t_block();
    retrip_mode = 2'd1;
    int_init = 3'b001; oc_flag = 3'b001;
    ticks(100);
    check("R10 precondition backtrip", 8'hC9);
    block_in = 1'b1;
    @(negedge clk);
    check("R10 block clears outputs", 8'h00);
    ticks(30);
    check("R10 outputs held low under block", 8'h00);
    block_in = 1'b0;
    ticks(59);
    check("R10 delay restarts after release", 8'h00);
    ticks(1);
    check("R10 retrip after full delay", 8'h01);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset state", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    t_normal_clear();
    t_fail_mode(2'd0);
    t_fail_mode(2'd1);
    t_fail_mode(2'd2);
    t_direct_no_current();
    t_oc_dip();
    t_evolving();
    t_ext_start();
    t_bt_disabled();
    t_clamp();
    t_block();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule